// File: doc/BRIEF.md
# Binary32 floating-point adder

This block adds two single-precision (binary32) operands and returns the correctly rounded binary32 sum. Each word carries a sign bit, an 8-bit biased exponent and a 23-bit fraction. Each operand is unpacked and gets its hidden significand bit back. The operand with the smaller magnitude is shifted right to line up with the larger one. The two magnitudes are then added when the signs agree. When the signs differ, the smaller magnitude is subtracted from the larger one. The sum is normalized, rounded to nearest with ties to even, and packed again.

The datapath works in sign and magnitude. It never turns a significand into a signed two's-complement value. When the signs differ, the result takes the sign of the larger-magnitude operand. The alignment shift keeps guard, round and sticky bits, so every bit lost during alignment or normalization still counts toward rounding. Subnormal operands take part fully. NaN and infinity operands go through a small bypass path. With the default setting the result is registered, so it appears one clock after the operands.

Top module: `fp_adder_rne`

## Requirements
- R1: For finite operands, `sum` is the binary32 sum rounded to nearest with ties to even. For example, 0x3FC00000 + 0x40500000 gives 0x40980000.
- R2: When the signs differ, the smaller magnitude is subtracted from the larger, the result takes the sign of the larger operand, and it is normalized with a left shift. Examples: 0x449EBBC8 + 0xC60EB709 gives 0xC5F5BF20, and 0x3F800001 + 0xBF800000 gives 0x34000000.
- R3: An exact cancellation of opposite-signed equal magnitudes gives +0 (0x00000000). A sum of two zeros of the same sign keeps that sign.
- R4: A tie sits exactly half a unit in the last place away. It rounds to the value whose fraction LSB (bit 0) is 0. Example: 0x3F800000 + 0x33800000 gives 0x3F800000, and 0x3F800001 + 0x33800000 gives 0x3F800002.
- R5: Bits shifted out during alignment are kept as sticky information. Example: 0x3F800000 + 0x33800001 rounds up to 0x3F800001.
- R6: A subnormal operand (exponent field 0) uses exponent 1 and hidden bit 0. A result below the normal range is packed with exponent field 0. Example: 0x007FFFFF + 0x00000001 gives 0x00800000.
- R7: A result whose rounded exponent reaches 255 becomes infinity (exponent all ones, fraction 0) with the sign of the result.
- R8: If either operand is a NaN (exponent all ones, fraction non-zero), or the operands are infinities of opposite sign, `sum` is 0x7FC00000.
- R9: An infinity added to a finite value or to an infinity of the same sign returns that infinity unchanged.
- R10: While `rst_n` is low, `sum` is 0. After reset, `sum` shows the result for the operands that were present at the previous rising clock edge.
- R11: Adding +0 to a finite non-zero operand returns that operand bit for bit.
- R12: When two finite operands share a sign, the result has that sign.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the result register |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a | input | 32 | First binary32 operand |
| op_b | input | 32 | Second binary32 operand |
| sum | output | 32 | Rounded binary32 sum |

## Verification
Fixed vectors with hand-computed results cover the following cases:
- the like-sign carry case, which needs one right shift;
- the mixed-sign case, which needs a left shift of several bits;
- exact cancellation;
- tie and just-above-tie rounding, which tell the even rule apart from the sticky bit;
- subnormal sums that cross into the normal range;
- overflow, including overflow caused by rounding;
- every special-value combination.

Beyond these, four random families are compared cycle by cycle against a wide-integer reference model in the bench:
- fully random words, which mostly hit large exponent gaps and specials;
- near-equal magnitudes with opposite signs, which force deep cancellation and long normalization shifts;
- operands with tiny exponents, which exercise the subnormal boundary;
- operands near the top of the range, which exercise overflow.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
   typedef enum logic [1:0] {
      FP_FINITE = 2'd0,
      FP_INF    = 2'd1,
      FP_NAN    = 2'd2
   } fp_class_e;
endpackage

// File: rtl/fpa_unpack.sv
module fpa_unpack
   import fpa_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int W     = 1 + EXP_W + FRAC_W
) (
   input  logic [W-1:0]      word_i,
   output logic              sign_o,
   output logic [EXP_W-1:0]  exp_o,
   output logic [FRAC_W:0]   sig_o,
   output fp_class_e         cls_o
);
   logic [EXP_W-1:0]  raw_exp;
   logic [FRAC_W-1:0] raw_frac;
   logic              exp_zero;

   assign sign_o   = word_i[W-1];
   assign raw_exp  = word_i[W-2:FRAC_W];
   assign raw_frac = word_i[FRAC_W-1:0];
   assign exp_zero = (raw_exp == '0);

   // subnormals behave as exponent 1 with no hidden bit
   assign exp_o = exp_zero ? EXP_W'(1) : raw_exp;
   assign sig_o = {~exp_zero, raw_frac};

   always_comb begin
      if (&raw_exp) cls_o = (raw_frac != '0) ? FP_NAN : FP_INF;
      else          cls_o = FP_FINITE;
   end
endmodule

// File: rtl/fpa_align.sv
module fpa_align #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int SIG_W = FRAC_W + 1,
   localparam int EXT_W = SIG_W + 3
) (
   input  logic              sign_a_i,
   input  logic [EXP_W-1:0]  exp_a_i,
   input  logic [SIG_W-1:0]  sig_a_i,
   input  logic              sign_b_i,
   input  logic [EXP_W-1:0]  exp_b_i,
   input  logic [SIG_W-1:0]  sig_b_i,
   output logic              sign_o,
   output logic              eff_sub_o,
   output logic [EXP_W-1:0]  exp_o,
   output logic [EXT_W-1:0]  big_o,
   output logic [EXT_W-1:0]  small_o
);
   logic              swap;
   logic [EXP_W-1:0]  small_exp;
   logic [SIG_W-1:0]  big_sig, small_sig;
   logic [EXP_W-1:0]  gap;
   logic [EXT_W-1:0]  small_raw, lost_mask;
   logic              sticky;

   // order by magnitude: exponent first, then significand
   assign swap      = {exp_b_i, sig_b_i} > {exp_a_i, sig_a_i};
   assign sign_o    = swap ? sign_b_i : sign_a_i;
   assign exp_o     = swap ? exp_b_i  : exp_a_i;
   assign small_exp = swap ? exp_a_i  : exp_b_i;
   assign big_sig   = swap ? sig_b_i  : sig_a_i;
   assign small_sig = swap ? sig_a_i  : sig_b_i;
   assign eff_sub_o = sign_a_i ^ sign_b_i;

   assign gap       = exp_o - small_exp;
   assign big_o     = {big_sig, 3'b000};
   assign small_raw = {small_sig, 3'b000};
   assign lost_mask = ~({EXT_W{1'b1}} << gap);
   assign sticky    = |(small_raw & lost_mask);
   assign small_o   = (small_raw >> gap) | EXT_W'(sticky);
endmodule

// File: rtl/fpa_norm_round.sv
module fpa_norm_round #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int SIG_W = FRAC_W + 1,
   localparam int EXT_W = SIG_W + 3,
   localparam int W     = 1 + EXP_W + FRAC_W
) (
   input  logic              sign_i,
   input  logic              eff_sub_i,
   input  logic [EXP_W-1:0]  exp_i,
   input  logic [EXT_W-1:0]  big_i,
   input  logic [EXT_W-1:0]  small_i,
   output logic [W-1:0]      word_o
);
   localparam int EW2      = EXP_W + 2;
   localparam int LZ_W     = $clog2(EXT_W + 1);
   localparam int RND_W    = SIG_W + 1;
   localparam int EXP_ONES = (1 << EXP_W) - 1;

   logic [EXT_W:0]    raw;
   logic [LZ_W-1:0]   lz;
   logic [EW2-1:0]    lim, sh, e1, e2;
   logic [EXT_W-1:0]  norm;
   logic [SIG_W-1:0]  keep;
   logic              up, hidden;
   logic [RND_W-1:0]  rnd;
   logic [FRAC_W-1:0] frac;

   always_comb begin
      raw = eff_sub_i ? ({1'b0, big_i} - {1'b0, small_i})
                      : ({1'b0, big_i} + {1'b0, small_i});
      // leading zeros below the carry position
      lz = LZ_W'(EXT_W);
      for (int i = 0; i < EXT_W; i++)
         if (raw[i]) lz = LZ_W'(EXT_W - 1 - i);
      lim = EW2'(exp_i) - EW2'(1);
      if (raw[EXT_W]) begin
         norm = {raw[EXT_W:2], |raw[1:0]};
         sh   = '0;
         e1   = EW2'(exp_i) + EW2'(1);
      end else begin
         sh   = (EW2'(lz) < lim) ? EW2'(lz) : lim;
         norm = raw[EXT_W-1:0] << sh;
         e1   = EW2'(exp_i) - sh;
      end
      keep   = norm[EXT_W-1:3];
      up     = norm[2] & (norm[1] | norm[0] | norm[3]);
      rnd    = {1'b0, keep} + RND_W'(up);
      hidden = rnd[SIG_W] | rnd[FRAC_W];
      e2     = e1 + EW2'(rnd[SIG_W]);
      frac   = rnd[SIG_W] ? '0 : rnd[FRAC_W-1:0];
      if (raw == '0)
         word_o = {sign_i & ~eff_sub_i, {(EXP_W + FRAC_W){1'b0}}};
      else if (e2 >= EW2'(EXP_ONES))
         word_o = {sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      else
         word_o = {sign_i, hidden ? e2[EXP_W-1:0] : {EXP_W{1'b0}}, frac};
   end
endmodule

// File: rtl/fp_adder_rne.sv
module fp_adder_rne
   import fpa_pkg::*;
#(
   parameter int EXP_W   = 8,
   parameter int FRAC_W  = 23,
   parameter int OUT_REG = 1,
   localparam int W      = 1 + EXP_W + FRAC_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [W-1:0]  op_a,
   input  logic [W-1:0]  op_b,
   output logic [W-1:0]  sum
);
   localparam int SIG_W = FRAC_W + 1;
   localparam int EXT_W = SIG_W + 3;
   localparam logic [W-1:0] QNAN =
      {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W - 1){1'b0}}};

   if (EXP_W < 3 || FRAC_W < 4) begin : g_bad_width
      $error("fp_adder_rne: EXP_W must be >= 3 and FRAC_W >= 4");
   end
   if (OUT_REG != 0 && OUT_REG != 1) begin : g_bad_reg
      $error("fp_adder_rne: OUT_REG must be 0 or 1");
   end

   logic [W-1:0]      opnd [2];
   logic              sgn  [2];
   logic [EXP_W-1:0]  ex   [2];
   logic [SIG_W-1:0]  sg   [2];
   fp_class_e         cl   [2];

   assign opnd[0] = op_a;
   assign opnd[1] = op_b;

   for (genvar gi = 0; gi < 2; gi++) begin : g_unp
      fpa_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp (
         .word_i (opnd[gi]),
         .sign_o (sgn[gi]),
         .exp_o  (ex[gi]),
         .sig_o  (sg[gi]),
         .cls_o  (cl[gi])
      );
   end

   logic              al_sign, al_sub;
   logic [EXP_W-1:0]  al_exp;
   logic [EXT_W-1:0]  al_big, al_small;
   logic [W-1:0]      arith, nxt;

   fpa_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
      .sign_a_i (sgn[0]), .exp_a_i (ex[0]), .sig_a_i (sg[0]),
      .sign_b_i (sgn[1]), .exp_b_i (ex[1]), .sig_b_i (sg[1]),
      .sign_o   (al_sign), .eff_sub_o (al_sub), .exp_o (al_exp),
      .big_o    (al_big),  .small_o   (al_small)
   );

   fpa_norm_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_nr (
      .sign_i    (al_sign),
      .eff_sub_i (al_sub),
      .exp_i     (al_exp),
      .big_i     (al_big),
      .small_i   (al_small),
      .word_o    (arith)
   );

   always_comb begin
      if (cl[0] == FP_NAN || cl[1] == FP_NAN ||
          (cl[0] == FP_INF && cl[1] == FP_INF && sgn[0] != sgn[1]))
         nxt = QNAN;
      else if (cl[0] == FP_INF) nxt = op_a;
      else if (cl[1] == FP_INF) nxt = op_b;
      else                      nxt = arith;
   end

   if (OUT_REG == 1) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sum <= '0;
         else        sum <= nxt;
      end
   end else begin : g_comb
      assign sum = nxt;
   end
endmodule

// File: rtl/fpa_checker.sv
module fpa_checker #(
   parameter int EXP_W   = 8,
   parameter int FRAC_W  = 23,
   parameter int OUT_REG = 1,
   localparam int W      = 1 + EXP_W + FRAC_W
) (
   input logic          clk,
   input logic          rst_n,
   input logic [W-1:0]  op_a,
   input logic [W-1:0]  op_b,
   input logic [W-1:0]  sum
);
   localparam logic [W-1:0] QNAN =
      {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W - 1){1'b0}}};
   localparam logic [W-1:0] SIGN_BIT = {1'b1, {(W - 1){1'b0}}};

   function automatic logic all_ones_exp(input logic [W-1:0] w);
      return &w[W-2:FRAC_W];
   endfunction
   function automatic logic is_nan(input logic [W-1:0] w);
      return all_ones_exp(w) && (w[FRAC_W-1:0] != '0);
   endfunction
   function automatic logic is_inf(input logic [W-1:0] w);
      return all_ones_exp(w) && (w[FRAC_W-1:0] == '0);
   endfunction

   if (OUT_REG == 1) begin : g_chk
      assert_nan_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (is_nan(op_a) || is_nan(op_b)) |=> (sum == QNAN));

      assert_inf_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (is_inf(op_a) && !all_ones_exp(op_b)) |=> (sum == $past(op_a)));

      assert_cancel_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (!all_ones_exp(op_a) && op_b == (op_a ^ SIGN_BIT)) |=> (sum == '0));

      assert_plus_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
         (!all_ones_exp(op_a) && op_a[W-2:0] != '0 && op_b == '0)
         |=> (sum == $past(op_a)));

      assert_like_sign_R12: assert property (@(posedge clk) disable iff (!rst_n)
         (!all_ones_exp(op_a) && !all_ones_exp(op_b) && op_a[W-1] == op_b[W-1])
         |=> (sum[W-1] == $past(op_a[W-1])));
   end
endmodule

bind fp_adder_rne fpa_checker #(
   .EXP_W(EXP_W), .FRAC_W(FRAC_W), .OUT_REG(OUT_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .sum(sum)
);

// File: tb/sim_fp_adder_rne.sv
`timescale 1ns/1ps
module sim_fp_adder_rne;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] op_a = '0;
   logic [31:0] op_b = '0;
   logic [31:0] sum;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   bit          pend = 0;
   logic [31:0] pend_exp, pend_a, pend_b;
   string       pend_tag;

   localparam logic [31:0] QNAN = 32'h7FC00000;

   always #2.5 clk = ~clk;

   fp_adder_rne u0 (.clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .sum(sum));

   // wide-integer reference: exact sum, then one rounding step
   function automatic logic [31:0] ref_add(input logic [31:0] a, input logic [31:0] b);
      bit nan_a, nan_b, inf_a, inf_b;
      int ea, eb, eL, eS, d, p, e, k;
      logic [23:0] ma, mb, mL, mS;
      bit sL, sS;
      logic [95:0] x, y, r, keep, below;
      bit half, up;
      logic [24:0] mant;
      nan_a = (a[30:23] == 8'hFF) && (a[22:0] != 0);
      nan_b = (b[30:23] == 8'hFF) && (b[22:0] != 0);
      inf_a = (a[30:23] == 8'hFF) && (a[22:0] == 0);
      inf_b = (b[30:23] == 8'hFF) && (b[22:0] == 0);
      if (nan_a || nan_b) return QNAN;
      if (inf_a && inf_b) return (a[31] != b[31]) ? QNAN : a;
      if (inf_a) return a;
      if (inf_b) return b;
      ea = (a[30:23] == 0) ? 1 : int'(a[30:23]);
      eb = (b[30:23] == 0) ? 1 : int'(b[30:23]);
      ma = {a[30:23] != 0, a[22:0]};
      mb = {b[30:23] != 0, b[22:0]};
      if (ea > eb || (ea == eb && ma >= mb)) begin
         sL = a[31]; eL = ea; mL = ma; sS = b[31]; eS = eb; mS = mb;
      end else begin
         sL = b[31]; eL = eb; mL = mb; sS = a[31]; eS = ea; mS = ma;
      end
      d = eL - eS;
      x = 96'(mL) << 42;
      y = (d > 40) ? 96'(mS != 0) : (96'(mS) << (42 - d));
      r = (sL == sS) ? x + y : x - y;
      if (r == 0) return (sL == sS) ? {sL, 31'b0} : 32'h0;
      p = 0;
      for (int i = 0; i < 96; i++) if (r[i]) p = i;
      e = eL + p - 65;
      if (e < 1) e = 1;
      k = e - eL + 42;
      if (k <= 0) begin
         keep = r << (-k); half = 0; below = 0;
      end else begin
         keep  = r >> k;
         half  = r[k-1];
         below = r & ((96'd1 << (k - 1)) - 96'd1);
      end
      up   = half && ((below != 0) || keep[0]);
      mant = keep[24:0] + 25'(up);
      if (mant[24]) begin mant = mant >> 1; e = e + 1; end
      if (e >= 255) return {sL, 8'hFF, 23'h0};
      return {sL, mant[23] ? 8'(e) : 8'h00, mant[22:0]};
   endfunction

   task automatic check(input logic [31:0] act, input logic [31:0] expv, input string tag,
                        input logic [31:0] a, input logic [31:0] b);
      checks++;
      if (act !== expv) begin
         fails++;
         $display("FAIL %s: a=%h b=%h sum=%h expected=%h", tag, a, b, act, expv);
      end
   endtask

   task automatic step(input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] expv, input string tag);
      @(negedge clk);
      if (pend) check(sum, pend_exp, pend_tag, pend_a, pend_b);
      op_a = a; op_b = b;
      pend = 1; pend_exp = expv; pend_tag = tag; pend_a = a; pend_b = b;
   endtask

   task automatic rstep(input logic [31:0] a, input logic [31:0] b, input string tag);
      step(a, b, ref_add(a, b), tag);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(sum, 32'h0, "R10 reset value", op_a, op_b);
      op_a = 32'h3F800000; op_b = 32'h40000000;
      @(negedge clk);
      check(sum, 32'h0, "R10 held in reset", op_a, op_b);
      rst_n = 1'b1;

      step(32'h3FC00000, 32'h40500000, 32'h40980000, "R1 carry renormalize");
      step(32'h449EBBC8, 32'hC60EB709, 32'hC5F5BF20, "R2 mixed signs");
      step(32'h3F800001, 32'hBF800000, 32'h34000000, "R2 deep left shift");
      step(32'h3F800000, 32'hB3800000, 32'h3F7FFFFF, "R2 borrow below one");
      step(32'h3F900000, 32'hBF900000, 32'h00000000, "R3 exact cancel");
      step(32'h80000000, 32'h80000000, 32'h80000000, "R3 neg zeros");
      step(32'h00000000, 32'h80000000, 32'h00000000, "R3 mixed zeros");
      step(32'h3F800000, 32'h33800000, 32'h3F800000, "R4 tie stays even");
      step(32'h3F800001, 32'h33800000, 32'h3F800002, "R4 tie rounds to even");
      step(32'h3F800000, 32'h33800001, 32'h3F800001, "R5 sticky rounds up");
      step(32'h00000001, 32'h00000001, 32'h00000002, "R6 subnormal sum");
      step(32'h007FFFFF, 32'h00000001, 32'h00800000, "R6 into normal range");
      step(32'h00800000, 32'h80000001, 32'h007FFFFF, "R6 into subnormal range");
      step(32'h7F7FFFFF, 32'h7F7FFFFF, 32'h7F800000, "R7 overflow pos");
      step(32'hFF7FFFFF, 32'hFF7FFFFF, 32'hFF800000, "R7 overflow neg");
      step(32'h7F7FFFFF, 32'h73000000, 32'h7F800000, "R7 rounding overflow");
      step(32'h7FC00000, 32'h3F800000, QNAN,         "R8 quiet nan in");
      step(32'h7F800001, 32'h00000000, QNAN,         "R8 signalling nan in");
      step(32'h7F800000, 32'hFF800000, QNAN,         "R8 inf minus inf");
      step(32'h7F800000, 32'hC0000000, 32'h7F800000, "R9 inf plus finite");
      step(32'hFF800000, 32'h7F7FFFFF, 32'hFF800000, "R9 neg inf");
      step(32'h7F800000, 32'h7F800000, 32'h7F800000, "R9 inf plus inf");
      step(32'h40490FDB, 32'h00000000, 32'h40490FDB, "R11 plus zero");
      step(32'h80000000, 32'hC0000000, 32'hC0000000, "R11 zero operand");
      step(32'hC0000000, 32'hC0400000, 32'hC0A00000, "R12 like negative");

      for (int n = 0; n < 800; n++)
         rstep($urandom, $urandom, "R1 random words");
      for (int n = 0; n < 800; n++) begin
         logic [31:0] a;
         a = $urandom;
         a[30:23] = 8'($urandom_range(1, 250));
         rstep(a, {~a[31], a[30:23], 23'($urandom)}, "R2 near cancel");
      end
      for (int n = 0; n < 300; n++)
         rstep({1'($urandom), 8'($urandom_range(0, 2)), 23'($urandom)},
               {1'($urandom), 8'($urandom_range(0, 2)), 23'($urandom)}, "R6 tiny exponents");
      for (int n = 0; n < 200; n++)
         rstep({1'($urandom), 8'($urandom_range(250, 254)), 23'($urandom)},
               {1'($urandom), 8'($urandom_range(225, 254)), 23'($urandom)}, "R7 near top");
      for (int n = 0; n < 200; n++) begin
         logic [31:0] a;
         a = $urandom;
         a[30:23] = 8'($urandom_range(110, 140));
         rstep(a, {a[31], 8'($urandom_range(80, 140)), 23'($urandom)}, "R12 like sign");
      end

      step(32'h0, 32'h0, 32'h0, "R10 flush");
      @(negedge clk);
      check(sum, pend_exp, pend_tag, pend_a, pend_b);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule